// File: doc/BRIEF.md
# Video Line Buffer

This block sits between a frame memory that delivers pixels in fast, bursty transfers and a video pipeline that needs one pixel on every pixel clock with no gaps. Whenever the display-enable input falls at the end of an active line, the block asks the memory arbiter for the next line. The request carries the line's start address and stays raised until it is acknowledged. The arbiter then writes the whole line of `LINE_PIX` one-byte pixels as a single burst on the fast write clock. That burst may pause, for example where the memory crosses a page, and each pause shows up as a low cycle on the write-valid input. When the last pixel is in, the block returns a one-cycle done pulse.

On the pixel clock the block sends the stored pixels out in order while display enable is high. The read position starts again at the first pixel on every rising edge of display enable. There is a single line store of `DEPTH` bytes. Successive lines are laid out in it circularly, each one starting `LINE_PIX` bytes after the previous one, modulo `DEPTH`. No second buffer is needed because the fill runs far ahead of the drain. The read side tracks how far the fill has progressed through a Gray-coded write pointer that passes through a two-flop synchronizer. If the drain ever reaches a pixel that has not yet been written, it holds its last output and raises a sticky underrun flag.

The request toggle and the done toggle each cross between the clock domains through two-flop synchronizers. The single reset input is asserted asynchronously and released synchronously in each domain.

Top module: `video_line_buffer`

## Requirements
- R1: While reset is asserted, `line_req_o`, `fill_done_o` and `underrun_o` are low and `pix_o` is zero. After reset is released, the block raises one request for the first line, carrying the value of `line_base_i`.
- R2: A falling edge of `de_i` raises `line_req_o`, with `line_addr_o` equal to the `line_base_i` value at that edge. The request and its address stay unchanged until `line_ack_i` is sampled high.
- R3: After the acknowledge, exactly `LINE_PIX` beats are stored, where a beat is a `wclk` cycle with `fill_valid_i` high. Cycles with `fill_valid_i` low are gaps and store nothing. Beats offered while no fill is running, including while the request is still waiting, are ignored.
- R4: `fill_done_o` is high for exactly one `wclk` cycle: the cycle that follows the edge on which the last beat of the line was accepted.
- R5: On each `pclk` edge where `de_i` is high and the next pixel has been written, that pixel is read. It appears on `pix_o` after that edge, and the pixels come out in the order they were written.
- R6: A rising edge of `de_i` restarts reading at the first pixel of the line. While `de_i` is low, `pix_o` holds its value.
- R7: If `de_i` is high while the read position points at a pixel not yet written, `underrun_o` is set and stays set until reset. While this lasts, `pix_o` repeats the last valid pixel and the read position does not advance.
- R8: A falling edge of `de_i` that arrives while the previous line's fill is still incomplete issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Fill-side (memory) clock |
| pclk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| line_req_o | output | 1 | Line fetch request to the arbiter (wclk) |
| line_addr_o | output | ADDR_W | Start address of the requested line |
| line_ack_i | input | 1 | Arbiter accepts the request (wclk) |
| fill_valid_i | input | 1 | Write beat valid (wclk) |
| fill_data_i | input | PIX_W | Write beat pixel |
| fill_done_o | output | 1 | One-cycle pulse after the last pixel of the line |
| de_i | input | 1 | Display enable from the timing generator (pclk) |
| line_base_i | input | ADDR_W | Address of the next line to fetch (pclk) |
| pix_o | output | PIX_W | Pixel to the downstream stage (pclk) |
| underrun_o | output | 1 | Sticky flag: the drain overtook the fill |

## Verification
Two events can fall in the same pixel cycle: the drain trying to read a line whose fill has not been acknowledged, and the line-end trigger arriving while that fill is still pending. The bench provokes both by holding the acknowledge back after a line-end request and then raising display enable for a short line. It expects the underrun flag to rise, the previous line's last pixel to be held on the output, and the second line-end to be dropped. After the late fill, a clean next line must still play out in order, no extra request may appear, and the underrun flag must remain set.

// File: rtl/vlb_pkg.sv
package vlb_pkg;
  typedef enum logic [1:0] {
    FILL_IDLE = 2'd0,
    FILL_REQ  = 2'd1,
    FILL_RUN  = 2'd2
  } fill_state_t;
endpackage

// File: rtl/vlb_sync.sv
module vlb_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/vlb_dpram.sv
module vlb_dpram #(
  parameter int W     = 8,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/vlb_fill.sv
module vlb_fill
  import vlb_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int LINE   = 640,
  parameter int AW     = 10,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_tgl_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              line_req_o,
  output logic [ADDR_W-1:0] line_addr_o,
  input  logic              line_ack_i,
  input  logic              fill_valid_i,
  input  logic [PIX_W-1:0]  fill_data_i,
  output logic              fill_done_o,
  output logic              done_tgl_o,
  output logic              we_o,
  output logic [AW-1:0]     waddr_o,
  output logic [PIX_W-1:0]  wdata_o,
  output logic [AW-1:0]     wgray_o
);
  localparam int CNT_W = $clog2(LINE + 1);

  fill_state_t       state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [AW-1:0]     wptr_q, wptr_d;
  logic [AW-1:0]     wgray_q, wgray_d;
  logic              seen_q, seen_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              done_q, done_d;
  logic              dtgl_q, dtgl_d;
  logic              we;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    wptr_d  = wptr_q;
    seen_d  = seen_q;
    addr_d  = addr_q;
    done_d  = 1'b0;
    dtgl_d  = dtgl_q;
    we      = 1'b0;
    case (state_q)
      FILL_IDLE: begin
        if (req_tgl_i != seen_q) begin
          seen_d  = req_tgl_i;
          addr_d  = addr_i;
          state_d = FILL_REQ;
        end
      end
      FILL_REQ: begin
        if (line_ack_i) begin
          state_d = FILL_RUN;
          cnt_d   = '0;
        end
      end
      FILL_RUN: begin
        if (fill_valid_i) begin
          we     = 1'b1;
          wptr_d = wptr_q + 1'b1;
          if (cnt_q == CNT_W'(LINE - 1)) begin
            state_d = FILL_IDLE;
            cnt_d   = '0;
            done_d  = 1'b1;
            dtgl_d  = ~dtgl_q;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: state_d = FILL_IDLE;
    endcase
    wgray_d = wptr_d ^ (wptr_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FILL_IDLE;
      cnt_q   <= '0;
      wptr_q  <= '0;
      wgray_q <= '0;
      seen_q  <= 1'b0;
      addr_q  <= '0;
      done_q  <= 1'b0;
      dtgl_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      wptr_q  <= wptr_d;
      wgray_q <= wgray_d;
      seen_q  <= seen_d;
      addr_q  <= addr_d;
      done_q  <= done_d;
      dtgl_q  <= dtgl_d;
    end
  end

  assign line_req_o  = (state_q == FILL_REQ);
  assign line_addr_o = addr_q;
  assign fill_done_o = done_q;
  assign done_tgl_o  = dtgl_q;
  assign we_o        = we;
  assign waddr_o     = wptr_q;
  assign wdata_o     = fill_data_i;
  assign wgray_o     = wgray_q;

  // R2: a waiting request keeps its level and address
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_req_o && !line_ack_i) |=> (line_req_o && $stable(line_addr_o)));

  // R4: the done indication lasts a single cycle
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done_o |=> !fill_done_o);

  // R3: never more than one line of beats per fill
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(LINE));
endmodule

// File: rtl/vlb_drain.sv
module vlb_drain #(
  parameter int LINE   = 640,
  parameter int AW     = 10,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              de_i,
  input  logic [ADDR_W-1:0] line_base_i,
  input  logic              done_tgl_i,
  input  logic [AW-1:0]     wgray_i,
  output logic              req_tgl_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              re_o,
  output logic [AW-1:0]     raddr_o,
  output logic              underrun_o
);
  localparam int OW = $clog2(LINE + 1);
  localparam int CW = ((OW > AW) ? OW : AW) + 1;

  logic              prime_q, prime_d;
  logic              de_q;
  logic              busy_q, busy_d;
  logic              rtgl_q, rtgl_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [AW-1:0]     cur_q, cur_d;
  logic [AW-1:0]     nxt_q, nxt_d;
  logic [OW-1:0]     off_q, off_d;
  logic              unr_q, unr_d;
  logic              dseen_q, dseen_d;

  logic [AW-1:0] wbin, avail;
  logic [OW-1:0] off_cur;
  logic          start, in_line, has_pix, rd, trig, accept, done_evt;

  always_comb begin
    for (int i = 0; i < AW; i++) wbin[i] = ^(wgray_i >> i);
  end

  always_comb begin
    avail    = wbin - cur_q;
    start    = de_i && !de_q;
    off_cur  = start ? '0 : off_q;
    in_line  = CW'(off_cur) < CW'(LINE);
    has_pix  = CW'(off_cur) < CW'(avail);
    rd       = de_i && in_line && has_pix;
    trig     = prime_q || (de_q && !de_i);
    accept   = trig && !busy_q;
    done_evt = (done_tgl_i != dseen_q);

    prime_d = 1'b0;
    busy_d  = busy_q;
    rtgl_d  = rtgl_q;
    addr_d  = addr_q;
    cur_d   = cur_q;
    nxt_d   = nxt_q;
    dseen_d = dseen_q;
    off_d   = rd ? (off_cur + 1'b1) : off_cur;
    unr_d   = unr_q | (de_i && in_line && !has_pix);
    if (done_evt) begin
      busy_d  = 1'b0;
      dseen_d = done_tgl_i;
    end
    if (accept) begin
      busy_d = 1'b1;
      rtgl_d = ~rtgl_q;
      addr_d = line_base_i;
      cur_d  = nxt_q;
      nxt_d  = nxt_q + AW'(LINE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prime_q <= 1'b1;
      de_q    <= 1'b0;
      busy_q  <= 1'b0;
      rtgl_q  <= 1'b0;
      addr_q  <= '0;
      cur_q   <= '0;
      nxt_q   <= '0;
      off_q   <= '0;
      unr_q   <= 1'b0;
      dseen_q <= 1'b0;
    end else begin
      prime_q <= prime_d;
      de_q    <= de_i;
      busy_q  <= busy_d;
      rtgl_q  <= rtgl_d;
      addr_q  <= addr_d;
      cur_q   <= cur_d;
      nxt_q   <= nxt_d;
      off_q   <= off_d;
      unr_q   <= unr_d;
      dseen_q <= dseen_d;
    end
  end

  assign req_tgl_o  = rtgl_q;
  assign addr_o     = addr_q;
  assign re_o       = rd;
  assign raddr_o    = cur_q + AW'(off_cur);
  assign underrun_o = unr_q;

  // R7: underrun stays set once raised
  p_unr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |=> underrun_o);

  // R5: read position never passes the end of the line
  p_off_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    off_q <= OW'(LINE));

  // R6: a new active line restarts at the first pixel
  p_line_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (de_i && !de_q) |=> (off_q <= OW'(1)));

  // R2: the address seen by the fill side stays put while a fill is pending
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done_evt) |=> $stable(addr_o));
endmodule

// File: rtl/video_line_buffer.sv
module video_line_buffer #(
  parameter int PIX_W    = 8,
  parameter int LINE_PIX = 640,
  parameter int DEPTH    = 1024,
  parameter int ADDR_W   = 24,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic              wclk,
  input  logic              pclk,
  input  logic              rst_n,
  output logic              line_req_o,
  output logic [ADDR_W-1:0] line_addr_o,
  input  logic              line_ack_i,
  input  logic              fill_valid_i,
  input  logic [PIX_W-1:0]  fill_data_i,
  output logic              fill_done_o,
  input  logic              de_i,
  input  logic [ADDR_W-1:0] line_base_i,
  output logic [PIX_W-1:0]  pix_o,
  output logic              underrun_o
);
  logic [1:0] wrs_q, prs_q;
  logic       wrst_n, prst_n;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) wrs_q <= 2'b00;
    else        wrs_q <= {wrs_q[0], 1'b1};
  end

  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) prs_q <= 2'b00;
    else        prs_q <= {prs_q[0], 1'b1};
  end

  assign wrst_n = wrs_q[1];
  assign prst_n = prs_q[1];

  logic              req_tgl_p, req_tgl_w;
  logic              done_tgl_w, done_tgl_p;
  logic [AW-1:0]     wgray_w, wgray_p;
  logic [ADDR_W-1:0] req_addr;
  logic              we, re;
  logic [AW-1:0]     waddr, raddr;
  logic [PIX_W-1:0]  wdata;

  vlb_sync #(.W(1)) u_req_sync (
    .clk(wclk), .rst_n(wrst_n), .d(req_tgl_p), .q(req_tgl_w));

  vlb_sync #(.W(1)) u_done_sync (
    .clk(pclk), .rst_n(prst_n), .d(done_tgl_w), .q(done_tgl_p));

  vlb_sync #(.W(AW)) u_ptr_sync (
    .clk(pclk), .rst_n(prst_n), .d(wgray_w), .q(wgray_p));

  vlb_fill #(
    .PIX_W(PIX_W), .LINE(LINE_PIX), .AW(AW), .ADDR_W(ADDR_W)
  ) u_fill (
    .clk          (wclk),
    .rst_n        (wrst_n),
    .req_tgl_i    (req_tgl_w),
    .addr_i       (req_addr),
    .line_req_o   (line_req_o),
    .line_addr_o  (line_addr_o),
    .line_ack_i   (line_ack_i),
    .fill_valid_i (fill_valid_i),
    .fill_data_i  (fill_data_i),
    .fill_done_o  (fill_done_o),
    .done_tgl_o   (done_tgl_w),
    .we_o         (we),
    .waddr_o      (waddr),
    .wdata_o      (wdata),
    .wgray_o      (wgray_w)
  );

  vlb_drain #(
    .LINE(LINE_PIX), .AW(AW), .ADDR_W(ADDR_W)
  ) u_drain (
    .clk         (pclk),
    .rst_n       (prst_n),
    .de_i        (de_i),
    .line_base_i (line_base_i),
    .done_tgl_i  (done_tgl_p),
    .wgray_i     (wgray_p),
    .req_tgl_o   (req_tgl_p),
    .addr_o      (req_addr),
    .re_o        (re),
    .raddr_o     (raddr),
    .underrun_o  (underrun_o)
  );

  vlb_dpram #(.W(PIX_W), .DEPTH(DEPTH)) u_ram (
    .wclk   (wclk),
    .we     (we),
    .waddr  (waddr),
    .wdata  (wdata),
    .rclk   (pclk),
    .rrst_n (prst_n),
    .re     (re),
    .raddr  (raddr),
    .rdata  (pix_o)
  );

  // R6, R7: without a read, the pixel output repeats its value
  p_pix_hold_r6: assert property (@(posedge pclk) disable iff (!prst_n)
    !re |=> $stable(pix_o));
endmodule

// File: tb/video_line_buffer_tb.sv
module video_line_buffer_tb;
  localparam int PIX_W  = 8;
  localparam int LINE   = 640;
  localparam int ADDR_W = 24;

  logic              wclk, pclk, rst_n;
  logic              line_req_o, line_ack_i, fill_valid_i, fill_done_o;
  logic [ADDR_W-1:0] line_addr_o, line_base_i;
  logic [PIX_W-1:0]  fill_data_i, pix_o;
  logic              de_i, underrun_o;

  video_line_buffer #(.PIX_W(PIX_W), .LINE_PIX(LINE), .DEPTH(1024), .ADDR_W(ADDR_W)) u_dut (
    .wclk(wclk), .pclk(pclk), .rst_n(rst_n),
    .line_req_o(line_req_o), .line_addr_o(line_addr_o), .line_ack_i(line_ack_i),
    .fill_valid_i(fill_valid_i), .fill_data_i(fill_data_i), .fill_done_o(fill_done_o),
    .de_i(de_i), .line_base_i(line_base_i), .pix_o(pix_o), .underrun_o(underrun_o));

  initial wclk = 1'b0;
  always #2 wclk = ~wclk;   // 250 MHz fill clock
  initial pclk = 1'b0;
  always #5 pclk = ~pclk;   // slower pixel clock

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int ln, input int i);
    return 8'((ln * 37) + (i * 5) + 3);
  endfunction

  // Behavioural reference: queue of pixels the display may consume
  logic [7:0] exp_q[$];
  logic [7:0] mpix;
  bit         munr;
  int         moff;
  bit         mde_q;
  bit         model_on = 0;

  always @(posedge pclk) begin
    if (model_on) begin
      if (de_i) begin
        if (!mde_q) moff = 0;
        if (moff < LINE) begin
          if (exp_q.size() > 0) begin
            mpix = exp_q.pop_front();
            moff++;
          end else begin
            munr = 1'b1;
          end
        end
      end
      mde_q = de_i;
    end
  end

  always @(negedge pclk) begin
    if (model_on && !finished) begin
      chk(pix_o == mpix, "R5", "pixel stream", pix_o, mpix);
      chk(underrun_o == munr, "R7", "underrun flag", underrun_o, munr);
    end
  end

  task automatic serve(input logic [ADDR_W-1:0] exp_addr, input int ln, input int mode);
    while (!line_req_o) @(negedge wclk);
    chk(line_addr_o == exp_addr, "R2", "request address", line_addr_o, exp_addr);
    for (int k = 0; k < 3; k++) begin   // junk beats while waiting: ignored (R3)
      fill_valid_i = 1'b1;
      fill_data_i  = 8'hEE;
      @(negedge wclk);
      chk(line_req_o && line_addr_o == exp_addr, "R2", "request held", line_addr_o, exp_addr);
    end
    fill_valid_i = 1'b0;
    line_ack_i   = 1'b1;
    @(negedge wclk);
    line_ack_i   = 1'b0;
    for (int i = 0; i < LINE; i++) begin
      int idle = (mode == 1) ? 1 : ((i != 0 && i % 256 == 0) ? 5 : 0);
      for (int g = 0; g < idle; g++) begin
        fill_valid_i = 1'b0;
        fill_data_i  = 8'hAA;
        @(negedge wclk);
        chk(fill_done_o == 1'b0, "R4", "done during gap", fill_done_o, 0);
      end
      fill_valid_i = 1'b1;
      fill_data_i  = pat(ln, i);
      @(negedge wclk);
      if (i == LINE - 1) chk(fill_done_o == 1'b1, "R4", "done after last beat", fill_done_o, 1);
      else               chk(fill_done_o == 1'b0, "R4", "done early", fill_done_o, 0);
    end
    for (int k = 0; k < 4; k++) begin   // junk after the fill: ignored (R3)
      fill_valid_i = 1'b1;
      fill_data_i  = 8'h11;
      @(negedge wclk);
      if (k == 0) chk(fill_done_o == 1'b0, "R4", "done width", fill_done_o, 0);
    end
    fill_valid_i = 1'b0;
  endtask

  task automatic show_line(input int ln, input logic [ADDR_W-1:0] next_base);
    repeat (20) @(negedge pclk);
    for (int i = 0; i < LINE; i++) exp_q.push_back(pat(ln, i));
    line_base_i = next_base;
    de_i = 1'b1;
    repeat (LINE) @(negedge pclk);
    de_i = 1'b0;
    repeat (3) @(negedge pclk);
    chk(pix_o == pat(ln, LINE - 1), "R6", "hold while blank", pix_o, pat(ln, LINE - 1));
  endtask

  initial begin
    rst_n = 1'b0; line_ack_i = 1'b0; fill_valid_i = 1'b0; fill_data_i = '0;
    de_i = 1'b0; line_base_i = 24'h000100;
    mpix = '0; munr = 1'b0; moff = 0; mde_q = 1'b0;
    repeat (6) @(negedge wclk);
    chk(line_req_o == 1'b0, "R1", "reset req", line_req_o, 0);
    chk(fill_done_o == 1'b0, "R1", "reset done", fill_done_o, 0);
    chk(pix_o == '0, "R1", "reset pixel", pix_o, 0);
    chk(underrun_o == 1'b0, "R1", "reset underrun", underrun_o, 0);
    @(negedge pclk);
    rst_n = 1'b1;
    model_on = 1;
    while (!line_req_o) @(negedge wclk);
    chk(line_addr_o == 24'h000100, "R1", "first request address", line_addr_o, 24'h000100);

    serve(24'h000100, 0, 0);           // page-crossing stalls
    show_line(0, 24'h000200);
    serve(24'h000200, 1, 1);           // gap on every other cycle
    show_line(1, 24'h000300);

    // Underrun: request for 0x300 left unacknowledged while display runs
    while (!line_req_o) @(negedge wclk);
    chk(line_addr_o == 24'h000300, "R2", "third request address", line_addr_o, 24'h000300);
    @(negedge pclk);
    line_base_i = 24'h000999;
    de_i = 1'b1;
    repeat (15) @(negedge pclk);
    chk(underrun_o == 1'b1, "R7", "underrun raised", underrun_o, 1);
    chk(pix_o == pat(1, LINE - 1), "R7", "last pixel repeated", pix_o, pat(1, LINE - 1));
    de_i = 1'b0;
    repeat (5) @(negedge pclk);
    serve(24'h000300, 2, 0);
    for (int k = 0; k < 30; k++) begin
      @(negedge wclk);
      chk(line_req_o == 1'b0, "R8", "dropped line end", line_req_o, 0);
    end
    show_line(2, 24'h000400);
    while (!line_req_o) @(negedge wclk);
    chk(line_addr_o == 24'h000400, "R2", "fourth request address", line_addr_o, 24'h000400);
    chk(underrun_o == 1'b1, "R7", "underrun sticky", underrun_o, 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge wclk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule